// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a page table held in memory. A request carries the virtual address, the kind of access (load, store or instruction fetch), a user/supervisor flag and a context number. The walk reads the context table entry first and then follows table pointers down through up to three levels. A leaf may appear at level 1, 2 or 3, which gives pages of 16 MB, 256 KB or 4 KB. Each descriptor is fetched through a plain read port: a one-cycle read strobe with an address, and a valid strobe with data some cycles later.

The result is a one-cycle response. It carries the physical address, the page size as a power of two, a read/write/execute permission set, an error code and the access index. The permission set comes from an 8-entry table indexed by the leaf's access field, and user and supervisor requests use different rows. Write permission is withheld while the leaf's modified bit is clear. Two bypasses skip the walk. Physical mode maps addresses one-to-one. In physical mode with the boot flag set, an instruction fetch is redirected into a boot ROM window.

Descriptor layout: bits [1:0] give the kind (0 invalid, 1 table pointer, 2 leaf, 3 reserved). A table pointer names the next table base as {bits[31:2], 2'b00} shifted left by 4. A leaf holds the physical page field in bits [31:8], the modified bit in bit 6 and the access field in bits [4:2].

Top module: `ptw_walker`

## Requirements
- R1: A walk reads the context entry at ctx_tbl_base + 4*context. It then reads the level-1 entry at base + 4*va[31:24], the level-2 entry at base + 4*va[23:18] and the level-3 entry at base + 4*va[17:12], in that order. It stops at the first leaf or error. Each read is a single-cycle mem_rd_en pulse.
- R2: A leaf at level 1 gives resp_lg_size 24 and adds va[23:12] as page offset.
- R3: A leaf at level 2 gives resp_lg_size 18 and adds va[17:12] as page offset.
- R4: A leaf at level 3 gives resp_lg_size 12 and adds no page offset.
- R5: The physical address is (leaf bits [31:8]) << 12, plus the page offset, plus va[11:0].
- R6: resp_acc_idx = {rw[0], rw[1], supervisor}, where rw is 0 for a load, 1 for a store and 2 for a fetch, and supervisor = !req_user.
- R7: When leaf bit 6 (modified) is clear, the write bit (bit 1) of resp_perm is forced to 0.
- R8: resp_perm uses the bit order {X,W,R}. For access field values 0 to 4 both rows give R, RW, RX, RWX and X. Value 5 gives R to a user and RW to a supervisor. Values 6 and 7 give nothing to a user, and RX and RWX to a supervisor.
- R9: If the table permission lacks the right that the request needs (W for a store, X for a fetch, R otherwise), resp_err = {2'b10, level}. That level is always 1 to 3.
- R10: An invalid or reserved descriptor, a leaf at the context level, or a table pointer at level 3 gives resp_err = {2'b01, level}, where level 0 is the context entry. Every error zeroes resp_paddr, resp_perm and resp_lg_size.
- R11: In physical mode with req_boot set, a fetch maps to ROM_BASE | va[18:0] with permission RX and size 12, and no memory read takes place.
- R12: In physical mode every other access maps to the zero-extended va with permission RWX and size 12, and no memory read takes place.
- R13: req_ready is high only when the walker is idle. resp_valid lasts exactly one cycle. After reset the walker is idle with no read and no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 32 | Virtual address |
| req_rw | input | 2 | 0 load, 1 store, 2 fetch |
| req_user | input | 1 | User-mode access |
| req_phys | input | 1 | Physical mode, no walk |
| req_boot | input | 1 | Boot redirect for fetches in physical mode |
| req_ctx | input | CTX_W | Context number |
| ctx_tbl_base | input | PA_W | Context table base address |
| mem_rd_en | output | 1 | Descriptor read strobe |
| mem_rd_addr | output | PA_W | Descriptor byte address |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Descriptor word |
| resp_valid | output | 1 | Result strobe |
| resp_paddr | output | PA_W | Physical address |
| resp_lg_size | output | 5 | log2 of page size |
| resp_perm | output | 3 | Permissions {X,W,R} |
| resp_err | output | 4 | {kind, level}, 0 = success |
| resp_acc_idx | output | 3 | Access index |

## Verification
The bench places leaves at every level and builds the page offset from distinct bits. A walker that used the wrong offset slice or size for a level would therefore return a wrong address. Leaves with a clear modified bit but a writable access field catch a walker that lets write through, and also one that reports a protection fault where none is due. Table pointers at level 3, leaves at the context level, reserved kinds and user-denied access fields each expect a specific error code with its level, so a walker that miscounted levels would report the wrong one. The number of memory reads per request is checked too, which exposes an extra or missing level and any read issued in the bypass modes.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
package ptw_pkg;

    localparam int VA_W   = 32;
    localparam int DESC_W = 32;
    localparam int OFS_W  = 12;

    typedef enum logic [1:0] {
        DESC_INV = 2'd0,
        DESC_PTD = 2'd1,
        DESC_PTE = 2'd2,
        DESC_RSV = 2'd3
    } desc_kind_e;

    localparam logic [2:0] PERM_R = 3'b001;
    localparam logic [2:0] PERM_W = 3'b010;
    localparam logic [2:0] PERM_X = 3'b100;

    localparam logic [1:0] ERRK_INVALID = 2'd1;
    localparam logic [1:0] ERRK_PROT    = 2'd2;

    localparam logic [1:0] LVL_CTX = 2'd0;
    localparam logic [1:0] LVL_1   = 2'd1;
    localparam logic [1:0] LVL_2   = 2'd2;
    localparam logic [1:0] LVL_3   = 2'd3;

    localparam logic [1:0] RW_STORE = 2'd1;
    localparam logic [1:0] RW_FETCH = 2'd2;

    localparam logic [4:0] LG_4K   = 5'd12;
    localparam logic [4:0] LG_256K = 5'd18;
    localparam logic [4:0] LG_16M  = 5'd24;

    // access field -> {X,W,R}, user row differs for codes 5..7
    function automatic logic [2:0] perm_lookup(input logic [2:0] acc, input logic user);
        logic [2:0] p;
        case (acc)
            3'd0:    p = PERM_R;
            3'd1:    p = PERM_R | PERM_W;
            3'd2:    p = PERM_R | PERM_X;
            3'd3:    p = PERM_R | PERM_W | PERM_X;
            3'd4:    p = PERM_X;
            3'd5:    p = user ? PERM_R : (PERM_R | PERM_W);
            3'd6:    p = user ? 3'b000 : (PERM_R | PERM_X);
            default: p = user ? 3'b000 : (PERM_R | PERM_W | PERM_X);
        endcase
        return p;
    endfunction

    function automatic logic [2:0] needed_right(input logic [1:0] rw);
        logic [2:0] n;
        if (rw == RW_STORE)      n = PERM_W;
        else if (rw == RW_FETCH) n = PERM_X;
        else                     n = PERM_R;
        return n;
    endfunction

endpackage

// File: rtl/ptw_addr_gen.sv
`timescale 1ns/1ps
module ptw_addr_gen #(
    parameter int PA_W  = 36,
    parameter int CTX_W = 8
) (
    input  logic [1:0]       lvl,
    input  logic [PA_W-1:0]  tbl_base,
    input  logic [CTX_W-1:0] ctx,
    input  logic [31:12]     va_hi,
    output logic [PA_W-1:0]  desc_addr
);
    import ptw_pkg::*;

    localparam int IDX_W = (CTX_W > 8) ? CTX_W : 8;

    logic [IDX_W-1:0] idx;

    always_comb begin
        case (lvl)
            LVL_CTX: idx = IDX_W'(ctx);
            LVL_1:   idx = IDX_W'(va_hi[31:24]);
            LVL_2:   idx = IDX_W'(va_hi[23:18]);
            default: idx = IDX_W'(va_hi[17:12]);
        endcase
        desc_addr = tbl_base + PA_W'({idx, 2'b00});
    end

endmodule

// File: rtl/ptw_leaf_eval.sv
`timescale 1ns/1ps
module ptw_leaf_eval #(
    parameter int PA_W = 36
) (
    input  logic [23:0]     ppn,
    input  logic [2:0]      acc,
    input  logic            modified,
    input  logic [1:0]      lvl,
    input  logic [23:0]     va_lo,
    input  logic [1:0]      rw,
    input  logic            user,
    output logic [PA_W-1:0] paddr,
    output logic [4:0]      lg_size,
    output logic [2:0]      perm,
    output logic            prot_err
);
    import ptw_pkg::*;

    logic [PA_W-1:0] page_ofs;
    logic [2:0]      tbl_perm;

    always_comb begin
        case (lvl)
            LVL_1: begin
                page_ofs = PA_W'({va_lo[23:12], 12'h000});
                lg_size  = LG_16M;
            end
            LVL_2: begin
                page_ofs = PA_W'({va_lo[17:12], 12'h000});
                lg_size  = LG_256K;
            end
            default: begin
                page_ofs = '0;
                lg_size  = LG_4K;
            end
        endcase
        paddr    = PA_W'({ppn, 12'h000}) + page_ofs + PA_W'(va_lo[11:0]);
        tbl_perm = perm_lookup(acc, user);
        prot_err = ~|(tbl_perm & needed_right(rw));
        perm     = modified ? tbl_perm : (tbl_perm & ~PERM_W);
    end

endmodule

// File: rtl/ptw_bypass.sv
`timescale 1ns/1ps
module ptw_bypass #(
    parameter int              PA_W     = 36,
    parameter logic [PA_W-1:0] ROM_BASE = '0
) (
    input  logic [31:0]     va,
    input  logic [1:0]      rw,
    input  logic            boot,
    output logic [PA_W-1:0] paddr,
    output logic [2:0]      perm
);
    import ptw_pkg::*;

    always_comb begin
        if (boot && rw == RW_FETCH) begin
            paddr = ROM_BASE | PA_W'(va[18:0]);
            perm  = PERM_R | PERM_X;
        end else begin
            paddr = PA_W'(va);
            perm  = PERM_R | PERM_W | PERM_X;
        end
    end

endmodule

// File: rtl/ptw_walker.sv
`timescale 1ns/1ps
module ptw_walker #(
    parameter int              PA_W     = 36,
    parameter int              CTX_W    = 8,
    parameter logic [PA_W-1:0] ROM_BASE = PA_W'(36'hFF000_0000)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [31:0]      req_vaddr,
    input  logic [1:0]       req_rw,
    input  logic             req_user,
    input  logic             req_phys,
    input  logic             req_boot,
    input  logic [CTX_W-1:0] req_ctx,
    input  logic [PA_W-1:0]  ctx_tbl_base,
    output logic             mem_rd_en,
    output logic [PA_W-1:0]  mem_rd_addr,
    input  logic             mem_rd_valid,
    input  logic [31:0]      mem_rd_data,
    output logic             resp_valid,
    output logic [PA_W-1:0]  resp_paddr,
    output logic [4:0]       resp_lg_size,
    output logic [2:0]       resp_perm,
    output logic [3:0]       resp_err,
    output logic [2:0]       resp_acc_idx
);
    import ptw_pkg::*;

    typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_RESP} st_e;

    typedef struct packed {
        st_e              st;
        logic [1:0]       lvl;
        logic [31:0]      va;
        logic [1:0]       rw;
        logic             user;
        logic [CTX_W-1:0] ctx;
        logic [PA_W-1:0]  rd_addr;
        logic             rvld;
        logic [PA_W-1:0]  paddr;
        logic [4:0]       lg;
        logic [2:0]       perm;
        logic [3:0]       err;
        logic [2:0]       acc;
    } walk_t;

    walk_t walk_q, walk_d;

    // address generator operands
    logic [1:0]       ag_lvl;
    logic [PA_W-1:0]  ag_base;
    logic [CTX_W-1:0] ag_ctx;
    logic [31:12]     ag_va;
    logic [PA_W-1:0]  ag_addr;

    // leaf and bypass results
    logic [PA_W-1:0]  lf_paddr;
    logic [4:0]       lf_lg;
    logic [2:0]       lf_perm;
    logic             lf_prot;
    logic [PA_W-1:0]  bp_paddr;
    logic [2:0]       bp_perm;

    desc_kind_e       kind;
    logic             unused_pte_bits;

    assign kind            = desc_kind_e'(mem_rd_data[1:0]);
    assign unused_pte_bits = ^{mem_rd_data[7], mem_rd_data[5]};

    always_comb begin
        if (walk_q.st == ST_IDLE) begin
            ag_lvl  = LVL_CTX;
            ag_base = ctx_tbl_base;
            ag_ctx  = req_ctx;
            ag_va   = req_vaddr[31:12];
        end else begin
            ag_lvl  = walk_q.lvl + 2'd1;
            ag_base = PA_W'({mem_rd_data[31:2], 6'b000000});
            ag_ctx  = walk_q.ctx;
            ag_va   = walk_q.va[31:12];
        end
    end

    ptw_addr_gen #(.PA_W(PA_W), .CTX_W(CTX_W)) u_addr_gen (
        .lvl       (ag_lvl),
        .tbl_base  (ag_base),
        .ctx       (ag_ctx),
        .va_hi     (ag_va),
        .desc_addr (ag_addr)
    );

    ptw_leaf_eval #(.PA_W(PA_W)) u_leaf_eval (
        .ppn      (mem_rd_data[31:8]),
        .acc      (mem_rd_data[4:2]),
        .modified (mem_rd_data[6]),
        .lvl      (walk_q.lvl),
        .va_lo    (walk_q.va[23:0]),
        .rw       (walk_q.rw),
        .user     (walk_q.user),
        .paddr    (lf_paddr),
        .lg_size  (lf_lg),
        .perm     (lf_perm),
        .prot_err (lf_prot)
    );

    ptw_bypass #(.PA_W(PA_W), .ROM_BASE(ROM_BASE)) u_bypass (
        .va    (req_vaddr),
        .rw    (req_rw),
        .boot  (req_boot),
        .paddr (bp_paddr),
        .perm  (bp_perm)
    );

    always_comb begin
        walk_d      = walk_q;
        walk_d.rvld = 1'b0;
        case (walk_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    walk_d.va   = req_vaddr;
                    walk_d.rw   = req_rw;
                    walk_d.user = req_user;
                    walk_d.ctx  = req_ctx;
                    walk_d.acc  = {req_rw[0], req_rw[1], ~req_user};
                    if (req_phys) begin
                        walk_d.st    = ST_RESP;
                        walk_d.rvld  = 1'b1;
                        walk_d.paddr = bp_paddr;
                        walk_d.perm  = bp_perm;
                        walk_d.lg    = LG_4K;
                        walk_d.err   = 4'd0;
                    end else begin
                        walk_d.st      = ST_ISSUE;
                        walk_d.lvl     = LVL_CTX;
                        walk_d.rd_addr = ag_addr;
                    end
                end
            end
            ST_ISSUE: begin
                walk_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rd_valid) begin
                    walk_d.st    = ST_RESP;
                    walk_d.rvld  = 1'b1;
                    walk_d.paddr = '0;
                    walk_d.perm  = 3'b000;
                    walk_d.lg    = 5'd0;
                    walk_d.err   = {ERRK_INVALID, walk_q.lvl};
                    if (kind == DESC_PTD && walk_q.lvl != LVL_3) begin
                        walk_d.st      = ST_ISSUE;
                        walk_d.rvld    = 1'b0;
                        walk_d.lvl     = walk_q.lvl + 2'd1;
                        walk_d.rd_addr = ag_addr;
                    end else if (kind == DESC_PTE && walk_q.lvl != LVL_CTX) begin
                        if (lf_prot) begin
                            walk_d.err = {ERRK_PROT, walk_q.lvl};
                        end else begin
                            walk_d.err   = 4'd0;
                            walk_d.paddr = lf_paddr;
                            walk_d.perm  = lf_perm;
                            walk_d.lg    = lf_lg;
                        end
                    end
                end
            end
            default: begin
                walk_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            walk_q <= '0;
        end else begin
            walk_q <= walk_d;
        end
    end

    assign req_ready    = (walk_q.st == ST_IDLE);
    assign mem_rd_en    = (walk_q.st == ST_ISSUE);
    assign mem_rd_addr  = walk_q.rd_addr;
    assign resp_valid   = walk_q.rvld;
    assign resp_paddr   = walk_q.paddr;
    assign resp_lg_size = walk_q.lg;
    assign resp_perm    = walk_q.perm;
    assign resp_err     = walk_q.err;
    assign resp_acc_idx = walk_q.acc;

endmodule

module ptw_walker_chk #(
    parameter int PA_W = 36
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_ready,
    input logic            mem_rd_en,
    input logic            resp_valid,
    input logic [PA_W-1:0] resp_paddr,
    input logic [4:0]      resp_lg_size,
    input logic [2:0]      resp_perm,
    input logic [3:0]      resp_err
);
    // R13
    resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R13
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en || resp_valid) |-> !req_ready);

    // R1
    read_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    // R10
    err_zero_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_err != 4'd0) |->
        (resp_paddr == '0 && resp_perm == 3'b000 && resp_lg_size == 5'd0));

    // R2
    legal_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_err == 4'd0) |->
        (resp_lg_size == 5'd12 || resp_lg_size == 5'd18 || resp_lg_size == 5'd24));

    // R9
    prot_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_err[3:2] == 2'b10) |-> (resp_err[1:0] != 2'b00));

    // R12
    ok_has_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_err == 4'd0) |-> (resp_perm != 3'b000));
endmodule

bind ptw_walker ptw_walker_chk #(.PA_W(PA_W)) u_chk (.*);

// File: tb/ptw_walker_bench.sv
`timescale 1ns/1ps
module ptw_walker_bench;

    localparam int PA_W = 36;

    typedef struct packed {
        logic [7:0]  ctx;
        logic [31:0] va;
        logic [1:0]  rw;
        logic        user;
        logic        phys;
        logic        boot;
        logic [35:0] paddr;
        logic [4:0]  lg;
        logic [2:0]  perm;
        logic [3:0]  err;
        logic [2:0]  nrd;
    } vec_t;

    localparam int NV = 22;
    // ctx, va, rw, user, phys, boot, paddr, lg, perm, err, reads
    localparam vec_t VECS [NV] = '{
        '{8'd0, 32'h01ABC123, 2'd0, 1'b0, 1'b0, 1'b0, 36'h000BDF123, 5'd24, 3'b111, 4'h0, 3'd2}, // R2 R5
        '{8'd0, 32'h01000000, 2'd1, 1'b1, 1'b0, 1'b0, 36'h000123000, 5'd24, 3'b111, 4'h0, 3'd2}, // R2 R6
        '{8'd0, 32'h02000010, 2'd0, 1'b1, 1'b0, 1'b0, 36'h000456010, 5'd24, 3'b001, 4'h0, 3'd2}, // R7
        '{8'd0, 32'h02000010, 2'd1, 1'b0, 1'b0, 1'b0, 36'h000456010, 5'd24, 3'b001, 4'h0, 3'd2}, // R7 R9
        '{8'd0, 32'h03000000, 2'd0, 1'b0, 1'b0, 1'b0, 36'h000000000, 5'd0,  3'b000, 4'h5, 3'd2}, // R10
        '{8'd0, 32'h04000200, 2'd0, 1'b1, 1'b0, 1'b0, 36'h000000000, 5'd0,  3'b000, 4'h9, 3'd2}, // R8 R9
        '{8'd0, 32'h04000200, 2'd2, 1'b0, 1'b0, 1'b0, 36'h000789200, 5'd24, 3'b101, 4'h0, 3'd2}, // R8
        '{8'd0, 32'h05000000, 2'd0, 1'b0, 1'b0, 1'b0, 36'h000000000, 5'd0,  3'b000, 4'h5, 3'd2}, // R10
        '{8'd0, 32'h00075ABC, 2'd2, 1'b0, 1'b0, 1'b0, 36'h000AE5ABC, 5'd18, 3'b101, 4'h0, 3'd3}, // R3
        '{8'd0, 32'h00075ABC, 2'd1, 1'b1, 1'b0, 1'b0, 36'h000000000, 5'd0,  3'b000, 4'hA, 3'd3}, // R9
        '{8'd0, 32'h00080000, 2'd0, 1'b0, 1'b0, 1'b0, 36'h000000000, 5'd0,  3'b000, 4'h6, 3'd3}, // R10
        '{8'd0, 32'h00000345, 2'd0, 1'b1, 1'b0, 1'b0, 36'hFEDCBA345, 5'd12, 3'b001, 4'h0, 3'd4}, // R4 R8
        '{8'd0, 32'h00000345, 2'd1, 1'b0, 1'b0, 1'b0, 36'hFEDCBA345, 5'd12, 3'b011, 4'h0, 3'd4}, // R4 R8
        '{8'd0, 32'h00000345, 2'd1, 1'b1, 1'b0, 1'b0, 36'h000000000, 5'd0,  3'b000, 4'hB, 3'd4}, // R9
        '{8'd0, 32'h00001000, 2'd0, 1'b0, 1'b0, 1'b0, 36'h000000000, 5'd0,  3'b000, 4'h7, 3'd4}, // R10
        '{8'd0, 32'h00002004, 2'd1, 1'b0, 1'b0, 1'b0, 36'h000333004, 5'd12, 3'b101, 4'h0, 3'd4}, // R7
        '{8'd1, 32'h00000345, 2'd0, 1'b0, 1'b0, 1'b0, 36'h000000000, 5'd0,  3'b000, 4'h4, 3'd1}, // R10
        '{8'd2, 32'h00000345, 2'd0, 1'b0, 1'b0, 1'b0, 36'h000000000, 5'd0,  3'b000, 4'h4, 3'd1}, // R10
        '{8'd0, 32'h12345678, 2'd0, 1'b0, 1'b1, 1'b0, 36'h012345678, 5'd12, 3'b111, 4'h0, 3'd0}, // R12
        '{8'd0, 32'h12345678, 2'd2, 1'b0, 1'b1, 1'b1, 36'hFF0045678, 5'd12, 3'b101, 4'h0, 3'd0}, // R11
        '{8'd0, 32'h12345678, 2'd0, 1'b1, 1'b1, 1'b1, 36'h012345678, 5'd12, 3'b111, 4'h0, 3'd0}, // R11 R12
        '{8'd0, 32'h12345678, 2'd2, 1'b1, 1'b1, 1'b0, 36'h012345678, 5'd12, 3'b111, 4'h0, 3'd0}  // R12
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [31:0]     req_vaddr = '0;
    logic [1:0]      req_rw = '0;
    logic            req_user = 1'b0;
    logic            req_phys = 1'b0;
    logic            req_boot = 1'b0;
    logic [7:0]      req_ctx = '0;
    logic [PA_W-1:0] ctx_tbl_base = '0;
    logic            mem_rd_en;
    logic [PA_W-1:0] mem_rd_addr;
    logic            mem_rd_valid = 1'b0;
    logic [31:0]     mem_rd_data = '0;
    logic            resp_valid;
    logic [PA_W-1:0] resp_paddr;
    logic [4:0]      resp_lg_size;
    logic [2:0]      resp_perm;
    logic [3:0]      resp_err;
    logic [2:0]      resp_acc_idx;

    logic [31:0] mem [1024];
    int          rd_cnt = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    int          cycles = 0;

    always #2.5 clk = ~clk;

    ptw_walker u_ptw_walker (
        .clk, .rst_n, .req_valid, .req_ready, .req_vaddr, .req_rw, .req_user,
        .req_phys, .req_boot, .req_ctx, .ctx_tbl_base, .mem_rd_en, .mem_rd_addr,
        .mem_rd_valid, .mem_rd_data, .resp_valid, .resp_paddr, .resp_lg_size,
        .resp_perm, .resp_err, .resp_acc_idx
    );

    // memory model: data one cycle after the read strobe
    always @(posedge clk) begin
        mem_rd_valid <= mem_rd_en;
        mem_rd_data  <= mem[mem_rd_addr[11:2]];
        if (mem_rd_en) rd_cnt <= rd_cnt + 1;
    end

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    task automatic run_vec(input vec_t v);
        int start_rd;
        int waited;
        @(negedge clk);
        start_rd  = rd_cnt;
        req_ctx   = v.ctx;
        req_vaddr = v.va;
        req_rw    = v.rw;
        req_user  = v.user;
        req_phys  = v.phys;
        req_boot  = v.boot;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        waited = 0;
        while (!resp_valid && waited < 100) begin
            // R13: no acceptance while a walk is in flight
            check("R13 ready while busy", 64'(req_ready), 64'd0);
            @(negedge clk);
            waited++;
        end
        check("R13 response arrived", 64'(resp_valid), 64'd1);
        check("R5 physical address", 64'(resp_paddr), 64'(v.paddr));
        check("R2 R3 R4 page size", 64'(resp_lg_size), 64'(v.lg));
        check("R7 R8 permission", 64'(resp_perm), 64'(v.perm));
        check("R9 R10 error code", 64'(resp_err), 64'(v.err));
        check("R6 access index", 64'(resp_acc_idx), 64'({v.rw[0], v.rw[1], ~v.user}));
        check("R1 R11 R12 read count", 64'(rd_cnt - start_rd), 64'(v.nrd));
        @(negedge clk);
        check("R13 single-cycle response", 64'(resp_valid), 64'd0);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        mem[10'h000] = 32'h00000041;  // ctx 0 -> level-1 table at 0x400
        mem[10'h001] = 32'h00000000;  // ctx 1 invalid
        mem[10'h002] = 32'h0001234E;  // ctx 2 leaf (illegal at context level)
        mem[10'h100] = 32'h00000081;  // L1[0] -> level-2 table at 0x800
        mem[10'h101] = 32'h0001234E;  // L1[1] leaf acc3 M=1
        mem[10'h102] = 32'h00045606;  // L1[2] leaf acc1 M=0
        mem[10'h103] = 32'h00000000;  // L1[3] invalid
        mem[10'h104] = 32'h0007895A;  // L1[4] leaf acc6 M=1
        mem[10'h105] = 32'h00000003;  // L1[5] reserved
        mem[10'h200] = 32'h000000C1;  // L2[0] -> level-3 table at 0xC00
        mem[10'h201] = 32'h000AB04A;  // L2[1] leaf acc2 M=1
        mem[10'h202] = 32'h00000000;  // L2[2] invalid
        mem[10'h300] = 32'hFEDCBA56;  // L3[0] leaf acc5 M=1
        mem[10'h301] = 32'h00000041;  // L3[1] table pointer at last level
        mem[10'h302] = 32'h0003330E;  // L3[2] leaf acc3 M=0

        repeat (3) @(negedge clk);
        // R13: reset state
        check("R13 reset ready", 64'(req_ready), 64'd1);
        check("R13 reset no response", 64'(resp_valid), 64'd0);
        check("R13 reset no read", 64'(mem_rd_en), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NV; k++) run_vec(VECS[k]);

        // R13: reset in the middle of a walk abandons it
        req_ctx   = 8'd0;
        req_vaddr = 32'h00000345;
        req_rw    = 2'd0;
        req_user  = 1'b0;
        req_phys  = 1'b0;
        req_boot  = 1'b0;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R13 mid-walk reset ready", 64'(req_ready), 64'd1);
        check("R13 mid-walk reset no response", 64'(resp_valid), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R13 idle after reset", 64'(resp_valid), 64'd0);

        // R1: walk resumes correctly after the aborted one
        run_vec(VECS[11]);

        finish_run();
    end

endmodule